// File: doc/BRIEF.md
# Parallel 16-bit host-bus master with ready stall

This block runs single read and write cycles from an internal request port to an external device, such as a programmable-logic companion, over separate address and data lines. A request is presented with address, write data and direction, and is launched by a one-clock start pulse while the master is idle. The cycle drives chip select low, raises the active-high read or write strobe for a programmable number of wait states, then keeps chip select low for a programmable capture (hold) width. A one-clock done pulse marks the end, and for reads the captured data is then valid on the request side.

The device can stretch a cycle in progress by pulling the active-low ready input low. Ready passes through a two-flop synchronizer. The stall takes hold a fixed number of clocks after ready falls. A two-bit ready-delay field does not change that onset. It sets only how many clocks pass after ready rises before the cycle moves on. A delay value of zero, or a cleared enable bit, makes the master ignore ready.

Top module: `hb16_stall_master`

## Requirements
- R1: After reset, bus_cs_n is 1, bus_rd, bus_wr, bus_doe and req_done are 0.
- R2: A read holds bus_cs_n low and bus_rd high for 1+cfg_rd_ws clocks, then keeps bus_cs_n low with both strobes low for cfg_cap clocks. req_rdata is the value of bus_din sampled at the clock edge that ends the last read-strobe clock.
- R3: A write raises bus_wr for 1+cfg_wr_ws clocks, followed by cfg_cap hold clocks. bus_doe is high and bus_dout equals the request's write data for as long as bus_cs_n is low.
- R4: bus_addr carries the request address and stays unchanged for as long as bus_cs_n is low.
- R5: req_start is accepted only while the master is idle. A start during a cycle leaves the address unchanged and launches no further cycle.
- R6: If bus_rdy_n is first sampled low at edge k, the cycle still advances at edges k, k+1 and k+2, whatever cfg_rdy_dly holds. While ready stays low, the cycle is frozen from edge k+3.
- R7: If bus_rdy_n is first sampled high again at edge m, the cycle stays frozen through edge m+1+cfg_rdy_dly and advances at edge m+2+cfg_rdy_dly (cfg_rdy_dly in 1..3).
- R8: While frozen, chip select, the active strobe, address and write data hold, and the hold phase does not count down. Read data is taken only on the final strobe edge that is not frozen.
- R9: With cfg_rdy_en = 0 or cfg_rdy_dly = 0, bus_rdy_n has no effect on cycle length.
- R10: req_done is high for exactly one clock, in the first clock with bus_cs_n high again. bus_rd and bus_wr are never high together, and neither is high while bus_cs_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rdy_en | input | 1 | Enable ready-based stalling |
| cfg_rdy_dly | input | 2 | Recovery clocks after ready rises; 0 disables stalling |
| cfg_rd_ws | input | 2 | Read wait states |
| cfg_wr_ws | input | 2 | Write wait states |
| cfg_cap | input | 2 | Hold clocks after the strobe |
| req_start | input | 1 | Start pulse, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Request address |
| req_wdata | input | 16 | Request write data |
| req_done | output | 1 | One-clock completion pulse |
| req_rdata | output | 16 | Captured read data |
| bus_addr | output | 20 | External address lines |
| bus_dout | output | 16 | External data driven on writes |
| bus_doe | output | 1 | Output enable for bus_dout |
| bus_din | input | 16 | External data sampled on reads |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_rd | output | 1 | Active-high read strobe |
| bus_wr | output | 1 | Active-high write strobe |
| bus_rdy_n | input | 1 | Active-low ready from the device |

## Verification
The same clock can hold both the final strobe edge and a ready stall. In that clock the freeze must win, and the read capture must move to the strobe edge that finally advances. This is provoked by dropping ready one clock into a long read and changing bus_din every clock. The bench judges it by comparing req_rdata with the value present in the last clock in which bus_rd was high, and by checking that the strobe length equals three advancing clocks plus the ready-low time plus the programmed recovery. A short write that ends before the stall can land checks the other side of this: the onset latency leaves that cycle's length unchanged.

// File: rtl/hb16_stall_master.sv
module hb16_stall_master #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_rdy_en,
  input  logic [CNT_W-1:0]  cfg_rdy_dly,
  input  logic [CNT_W-1:0]  cfg_rd_ws,
  input  logic [CNT_W-1:0]  cfg_wr_ws,
  input  logic [CNT_W-1:0]  cfg_cap,
  input  logic              req_start,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_done,
  output logic [DATA_W-1:0] req_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din,
  output logic              bus_cs_n,
  output logic              bus_rd,
  output logic              bus_wr,
  input  logic              bus_rdy_n
);

  typedef enum logic [1:0] {ST_IDLE, ST_STRB, ST_HOLD} phase_t;

  phase_t            phase_q;
  logic [CNT_W-1:0]  cnt_q, cap_q, rec_q;
  logic              wr_q, done_q, stall_q;
  logic              rdy_s1, rdy_s2;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  wire busy    = phase_q != ST_IDLE;
  wire adv     = !stall_q;
  wire armed   = cfg_rdy_en && (cfg_rdy_dly != '0);
  wire cnt_end = cnt_q == '0;

  assign bus_cs_n  = !busy;
  assign bus_rd    = (phase_q == ST_STRB) && !wr_q;
  assign bus_wr    = (phase_q == ST_STRB) && wr_q;
  assign bus_doe   = busy && wr_q;
  assign bus_addr  = addr_q;
  assign bus_dout  = wdata_q;
  assign req_done  = done_q;
  assign req_rdata = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_s1 <= 1'b1;
      rdy_s2 <= 1'b1;
    end else begin
      rdy_s1 <= bus_rdy_n;
      rdy_s2 <= rdy_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q <= 1'b0;
      rec_q   <= '0;
    end else if (!armed) begin
      stall_q <= 1'b0;
      rec_q   <= '0;
    end else if (!rdy_s2) begin
      stall_q <= 1'b1;
      rec_q   <= '0;
    end else if (stall_q) begin
      if (rec_q + 1'b1 == cfg_rdy_dly) begin
        stall_q <= 1'b0;
        rec_q   <= '0;
      end else begin
        rec_q <= rec_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ST_IDLE;
      cnt_q   <= '0;
      cap_q   <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        ST_IDLE: if (req_start) begin
          phase_q <= ST_STRB;
          cnt_q   <= req_write ? cfg_wr_ws : cfg_rd_ws;
          cap_q   <= cfg_cap;
          wr_q    <= req_write;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
        end
        ST_STRB: if (adv) begin
          if (cnt_end) begin
            if (!wr_q) rdata_q <= bus_din;
            if (cap_q == '0) begin
              phase_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              phase_q <= ST_HOLD;
              cnt_q   <= cap_q - 1'b1;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_HOLD: if (adv) begin
          if (cnt_end) begin
            phase_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: phase_q <= ST_IDLE;
      endcase
    end
  end

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  p_strobe_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> !bus_cs_n);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_addr));
  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stall_q) |=> ($stable(phase_q) && $stable(cnt_q) && $stable(req_rdata)));
  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !stall_q);
  p_doe_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> !bus_cs_n);

endmodule

// File: tb/hb16_stall_master_tb.sv
module hb16_stall_master_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_rdy_en = 1;
  logic [1:0] cfg_rdy_dly = 1, cfg_rd_ws = 0, cfg_wr_ws = 0, cfg_cap = 0;
  logic req_start = 0, req_write = 0;
  logic [19:0] req_addr = 0;
  logic [15:0] req_wdata = 0, bus_din = 0;
  logic bus_rdy_n = 1;
  logic req_done, bus_doe, bus_cs_n, bus_rd, bus_wr;
  logic [15:0] req_rdata, bus_dout;
  logic [19:0] bus_addr;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  hb16_stall_master u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_rdy_en(cfg_rdy_en), .cfg_rdy_dly(cfg_rdy_dly),
    .cfg_rd_ws(cfg_rd_ws), .cfg_wr_ws(cfg_wr_ws), .cfg_cap(cfg_cap),
    .req_start(req_start), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_done(req_done), .req_rdata(req_rdata),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
    .bus_cs_n(bus_cs_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdy_n(bus_rdy_n));

  // {write, ws, cap, addr, wdata}
  localparam logic [40:0] VEC [8] = '{
    {1'b0, 2'd0, 2'd0, 20'h00010, 16'h0000},
    {1'b1, 2'd0, 2'd0, 20'h00022, 16'h1234},
    {1'b0, 2'd3, 2'd1, 20'hABCDE, 16'h0000},
    {1'b1, 2'd3, 2'd3, 20'hFFFFF, 16'hFFFF},
    {1'b0, 2'd1, 2'd2, 20'h12345, 16'h0000},
    {1'b1, 2'd2, 2'd1, 20'h54321, 16'hA5A5},
    {1'b0, 2'd2, 2'd3, 20'h0F0F0, 16'h0000},
    {1'b1, 2'd1, 2'd0, 20'h80001, 16'h8001}};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input bit w, input logic [19:0] a, input logic [15:0] d,
                        input int ws, input int cap, input int dly, input bit en,
                        input int rdy_at, input int rdy_len, input int exp_s,
                        input int exp_h, input bit poke, input string tag);
    int s_cnt = 0, h_cnt = 0, last_din = 0;
    bit addr_ok = 1, data_ok = 1, seen = 0;
    @(negedge clk);
    cfg_rd_ws = 2'(ws); cfg_wr_ws = 2'(ws); cfg_cap = 2'(cap);
    cfg_rdy_dly = 2'(dly); cfg_rdy_en = en;
    req_write = w; req_addr = a; req_wdata = d; req_start = 1;
    for (int i = 1; i < 80; i++) begin
      @(negedge clk);
      req_start = 0;
      if (poke && i == 2) begin req_start = 1; req_addr = ~a; req_write = ~w; end
      if (i == rdy_at) bus_rdy_n = 0;
      if (i == rdy_at + rdy_len) bus_rdy_n = 1;
      if (req_done) begin
        seen = 1;
        chk(bus_cs_n == 1, {"R10 done with cs high ", tag}, bus_cs_n, 1);
        break;
      end
      if (bus_addr != a) addr_ok = 0;
      if (bus_rd || bus_wr) s_cnt++;
      else if (!bus_cs_n) h_cnt++;
      if (w && (!bus_doe || bus_dout != d)) data_ok = 0;
      if (!w && bus_doe) data_ok = 0;
      if (bus_rd && bus_wr) data_ok = 0;
      bus_din = 16'(16'hC000 + i * 7);
      if (bus_rd) last_din = bus_din;
    end
    req_start = 0;
    chk(seen, {"R10 done seen ", tag}, seen, 1);
    chk(s_cnt == exp_s, {"R2 R3 R6 R7 strobe length ", tag}, s_cnt, exp_s);
    chk(h_cnt == exp_h, {"R2 R8 hold length ", tag}, h_cnt, exp_h);
    chk(addr_ok, {"R4 address stable ", tag}, addr_ok, 1);
    chk(data_ok, {"R3 data drive ", tag}, data_ok, 1);
    if (!w) chk(req_rdata == 16'(last_din), {"R2 R8 read capture ", tag}, req_rdata, last_din);
    @(negedge clk);
    chk(req_done == 0, {"R10 done one clock ", tag}, req_done, 0);
    bus_rdy_n = 1;
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      if (poke) chk(bus_cs_n == 1, {"R5 no extra cycle ", tag}, bus_cs_n, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(bus_cs_n == 1 && !bus_rd && !bus_wr && !bus_doe && !req_done,
        "R1 reset state", {bus_cs_n, bus_rd, bus_wr, bus_doe, req_done}, 5'b10000);
    rst_n = 1;
    repeat (2) @(negedge clk);
    foreach (VEC[v]) begin
      run_op(VEC[v][40], VEC[v][35:16], VEC[v][15:0], int'(VEC[v][39:38]),
             int'(VEC[v][37:36]), 1, 1, -1, 0, 1 + int'(VEC[v][39:38]),
             int'(VEC[v][37:36]), 0, $sformatf("vec%0d", v));
    end
    // R6 R7 read stall, onset three edges, recovery by delay
    run_op(0, 20'h11111, 0, 3, 0, 1, 1, 1, 4, 8, 0, 0, "stall dly1");
    run_op(0, 20'h22222, 0, 3, 0, 3, 1, 1, 4, 10, 0, 0, "stall dly3");
    run_op(0, 20'h33333, 0, 3, 1, 2, 1, 1, 1, 6, 1, 0, "short stall dly2");
    run_op(0, 20'h44444, 0, 3, 0, 1, 1, 1, 20, 24, 0, 0, "long stall R6");
    // R6 short write ends before the stall lands
    run_op(1, 20'h55555, 16'h5A5A, 1, 0, 3, 1, 1, 6, 2, 0, 0, "onset late R6");
    // R7 R3 write stall with hold phase
    run_op(1, 20'h66666, 16'h0F0F, 3, 2, 2, 1, 1, 2, 7, 2, 0, "write stall");
    // R8 stall lands in hold phase
    run_op(0, 20'h77777, 0, 0, 3, 1, 1, 1, 4, 1, 7, 0, "hold stall R8");
    // R9 ready ignored
    run_op(0, 20'h88888, 0, 3, 0, 0, 1, 1, 4, 4, 0, 0, "dly0 R9");
    run_op(1, 20'h99999, 16'h9999, 3, 1, 2, 0, 1, 4, 4, 1, 0, "en0 R9");
    // R5 start while busy
    run_op(0, 20'hAAAAA, 0, 3, 2, 1, 1, -1, 0, 4, 2, 1, "start busy R5");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule